// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two binary numbers that arrive one bit per clock, lowest bit first, and emits their sum in the same serial order. A single full-adder cell does the arithmetic. A one-bit carry register links each bit position to the next. A start-of-word flag travels beside the data. On the first bit of a word it forces the carry into the adder to zero, so words can follow one another with no gap and no per-word reset.

Each sum bit and a copy of the start flag are registered, so the output stream trails the input by exactly one clock. A valid qualifier lets the source pause. During a pause the carry and the output bits hold their values. Word length is free. A word ends when the next start flag is taken. At that moment the stored carry, which is the carry out of the previous word's top bit, is flagged on a separate output.

Top module: `bitser_adder`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `out_sum`, `out_lsb` and `word_cout` are all 0.
- R2: When `in_vld` is 1 at a rising edge, then after that edge `out_vld` is 1 and `out_sum` equals `in_a ^ in_b ^ cin`. Here `cin` is 0 on a start bit and the stored carry otherwise.
- R3: After a valid bit, the stored carry (shown on `word_cout`) becomes the majority of `in_a`, `in_b` and `cin`.
- R4: A valid bit with `in_lsb` = 1 is added with a carry-in of 0, whatever carry is stored.
- R5: After a valid bit, `out_lsb` equals the `in_lsb` of that bit, so it lines up with the `out_sum` bit it marks.
- R6: A cycle with `in_vld` = 0 leaves `out_sum`, `out_lsb` and the stored carry unchanged, and drives `out_vld` to 0 after the edge.
- R7: `word_cout_vld` is 1 exactly when `in_vld` and `in_lsb` are both 1 and at least one valid bit has been taken since reset. While it is 1, `word_cout` is the carry out of the previous word's last bit.
- R8: Any word length from one bit upward is accepted, including consecutive one-bit words and words separated by pauses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input bit is valid this cycle |
| in_lsb | input | 1 | Input bit is the lowest bit of a new word |
| in_a | input | 1 | Serial operand A bit |
| in_b | input | 1 | Serial operand B bit |
| out_vld | output | 1 | Output bit is valid this cycle |
| out_lsb | output | 1 | Output bit is the lowest bit of a word |
| out_sum | output | 1 | Serial sum bit |
| word_cout | output | 1 | Stored carry; carry out of the finished word at a word boundary |
| word_cout_vld | output | 1 | `word_cout` holds a finished word's carry |

## Verification
The assertions assume the source marks the first bit of every word with `in_lsb`. They also assume the data inputs are defined whenever `in_vld` is high; during a pause the data inputs may hold anything.

The stimulus holds to this. Every word it sends opens with a start bit. Pause cycles are inserted at random with garbage on the data and start-flag pins, which checks that such values are ignored. Random 8-bit and 16-bit words are mixed with all-ones carry chains and runs of one-bit words.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Registered state of the serial adder
    typedef struct packed {
        logic carry;   // carry into the next bit position
        logic open_w;  // a valid bit has been taken since reset
        logic sum;     // registered sum bit
        logic lsb;     // registered start-of-word flag
        logic vld;     // registered valid
    } bsa_state_t;

endpackage

// File: rtl/bsa_full_add.sv
module bsa_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end

endmodule

// File: rtl/bsa_frame_ctl.sv
module bsa_frame_ctl (
    input  logic vld,
    input  logic lsb,
    input  logic carry_q,
    input  logic open_q,
    output logic cin,
    output logic close_w
);

    always_comb begin
        // a start bit ignores the carry left by the previous word
        cin     = lsb ? 1'b0 : carry_q;
        // the previous word is finished when a new start bit is taken
        close_w = vld & lsb & open_q;
    end

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_lsb,
    input  logic in_a,
    input  logic in_b,
    output logic out_vld,
    output logic out_lsb,
    output logic out_sum,
    output logic word_cout,
    output logic word_cout_vld
);

    import bsa_pkg::*;

    bsa_state_t st_d, st_q;
    logic       cin_w;
    logic       fa_s, fa_co;
    logic       close_w;

    bsa_frame_ctl u_frame (
        .vld     (in_vld),
        .lsb     (in_lsb),
        .carry_q (st_q.carry),
        .open_q  (st_q.open_w),
        .cin     (cin_w),
        .close_w (close_w)
    );

    bsa_full_add u_fa (
        .a  (in_a),
        .b  (in_b),
        .ci (cin_w),
        .s  (fa_s),
        .co (fa_co)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.carry  = fa_co;
            st_d.sum    = fa_s;
            st_d.lsb    = in_lsb;
            st_d.open_w = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld       = st_q.vld;
    assign out_lsb       = st_q.lsb;
    assign out_sum       = st_q.sum;
    assign word_cout     = st_q.carry;
    assign word_cout_vld = close_w;

    // R2: valid bit gives its sum one cycle later
    p_sum_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld && (out_sum == ($past(in_a) ^ $past(in_b) ^
                   ($past(in_lsb) ? 1'b0 : $past(word_cout)))));

    // R3: two ones always produce a carry, two zeros never do
    p_carry_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_a && in_b) |=> word_cout);
    p_carry_kill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_a && !in_b) |=> !word_cout);

    // R4: a start bit with at most one operand set cannot carry
    p_lsb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_lsb && !(in_a && in_b)) |=> !word_cout);

    // R5: start flag follows its bit by one cycle
    p_lsb_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_lsb == $past(in_lsb)));

    // R6: a pause changes nothing but the valid flag
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld && $stable(out_sum) && $stable(out_lsb) && $stable(word_cout));

    // R7: word carry only flagged on a taken start bit
    p_cout_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_cout_vld |-> (in_vld && in_lsb));

endmodule

// File: tb/bitser_adder_tb.sv
module bitser_adder_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, in_lsb = 1'b0, in_a = 1'b0, in_b = 1'b0;
    logic out_vld, out_lsb, out_sum, word_cout, word_cout_vld;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model state
    logic mcarry = 1'b0;
    logic mopen = 1'b0;
    logic lsum = 1'b0;
    logic llsb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitser_adder u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_lsb(in_lsb),
        .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_lsb(out_lsb),
        .out_sum(out_sum), .word_cout(word_cout), .word_cout_vld(word_cout_vld)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic maj(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // one cycle of stimulus, with checks on both sides of the edge
    task automatic step(input logic v, input logic l, input logic a, input logic b);
        logic cin, es, ec, ecv;
        @(negedge clk);
        in_vld = v; in_lsb = l; in_a = a; in_b = b;
        #1;
        ecv = v && l && mopen;
        chk(word_cout_vld == ecv, "R7 word_cout_vld", word_cout_vld, ecv);
        if (ecv) chk(word_cout == mcarry, "R7 word_cout", word_cout, mcarry);
        cin = l ? 1'b0 : mcarry;
        es  = a ^ b ^ cin;
        ec  = maj(a, b, cin);
        @(posedge clk);
        #1;
        if (v) begin
            chk(out_vld == 1'b1, "R2 out_vld", out_vld, 1);
            chk(out_sum == es, l ? "R4 start-bit sum" : "R2 sum", out_sum, es);
            chk(out_lsb == l, "R5 out_lsb", out_lsb, l);
            chk(word_cout == ec, "R3 carry", word_cout, ec);
            mcarry = ec; mopen = 1'b1; lsum = es; llsb = l;
        end else begin
            chk(out_vld == 1'b0, "R6 out_vld", out_vld, 0);
            chk(out_sum == lsum, "R6 out_sum hold", out_sum, lsum);
            chk(out_lsb == llsb, "R6 out_lsb hold", out_lsb, llsb);
            chk(word_cout == mcarry, "R6 carry hold", word_cout, mcarry);
        end
    endtask

    // one word of w bits, optional random pauses, reassembled and compared
    task automatic send_word(input int w, input logic [15:0] opa, input logic [15:0] opb,
                             input bit pauses);
        logic [16:0] ref_sum;
        logic [16:0] mask;
        logic [15:0] acc;
        ref_sum = {1'b0, opa} + {1'b0, opb};
        mask = (17'h1 << w) - 17'h1;
        ref_sum = ref_sum & ((17'h1 << (w + 1)) - 17'h1);
        if (w < 16) begin
            ref_sum = ({1'b0, opa} & mask) + ({1'b0, opb} & mask);
        end
        acc = '0;
        for (int i = 0; i < w; i++) begin
            if (pauses && ($urandom % 4 == 0))
                step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
            step(1'b1, (i == 0), opa[i], opb[i]);
            acc[i] = out_sum;
        end
        chk(({1'b0, acc} & mask) == (ref_sum & mask), "R8 word sum", acc, ref_sum & mask);
        chk(word_cout == ref_sum[w], "R7 final carry", word_cout, ref_sum[w]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #(CLK_PERIOD * 2 + 1);
        chk(out_vld == 0, "R1 out_vld", out_vld, 0);
        chk(out_sum == 0, "R1 out_sum", out_sum, 0);
        chk(out_lsb == 0, "R1 out_lsb", out_lsb, 0);
        chk(word_cout == 0, "R1 word_cout", word_cout, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed: long carry chain, then start bit must drop the carry (R4)
        send_word(16, 16'hFFFF, 16'h0001, 1'b0);
        send_word(8, 8'h00, 8'h00, 1'b0);
        send_word(16, 16'hFFFF, 16'hFFFF, 1'b1);
        send_word(8, 8'h01, 8'h00, 1'b0);
        // one-bit words back to back (R8)
        send_word(1, 16'h1, 16'h1, 1'b0);
        send_word(1, 16'h1, 16'h0, 1'b0);
        send_word(1, 16'h1, 16'h1, 1'b0);
        send_word(1, 16'h0, 16'h0, 1'b1);
        // long pause mid-stream (R6)
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b1, 1'b1);

        // random 8- and 16-bit words, back to back with random pauses
        for (int n = 0; n < 300; n++) begin
            send_word(($urandom % 2) ? 16 : 8, 16'($urandom), 16'($urandom), (n % 3) == 0);
        end
        // close the last word
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule